// File: doc/BRIEF.md
# Four-Channel DMA Request Priority Arbiter

This block decides which of four DMA channels may use the transfer engine next. Each channel raises a request line. The arbiter returns a one-hot grant, which it holds until the engine signals that the transfer is finished. A 16-bit control word, which the CPU reads and writes through a small register port, selects how competing requests are ranked. There are three fixed channel orderings and one rotating round-robin order.

The control word also carries a sticky fault bit. The bit is set when the transfer engine reports an address fault, and while it is set no channel receives a grant. Software cannot set the bit. Software clears it only by first reading the word while the bit shows 1 and then writing 0 to the bit. Because of this sequence, a stale or blind write cannot silently resume transfers.

The grant controller is a three-state machine. The states are `ST_IDLE` (no grant, a decision is made here), `ST_GRANT` (one channel holds the engine) and `ST_HALT` (the fault bit blocks all grants). It has the following transitions:
- ST_IDLE to ST_GRANT on any request.
- ST_IDLE to ST_HALT on a fault pulse or a set fault bit.
- ST_GRANT to ST_IDLE on the done strobe.
- ST_GRANT to ST_HALT on a fault pulse.
- ST_HALT to ST_IDLE once the bit is cleared.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset, `gnt` is 0 and a read of the control word returns 0x0000.
- R2: Control word bits 9:8 form the ordering mode field. It resets to 00, is written from `reg_wdata[9:8]` and reads back as written.
- R3: Every control word bit other than 9:8 and 2 always reads 0, whatever has been written.
- R4: With mode 00, the requesting channel chosen is the first present in the order 0, 1, 2, 3.
- R5: With mode 01, the order is 0, 2, 3, 1.
- R6: With mode 10, the order is 2, 0, 1, 3.
- R7: With mode 11, the order rotates. A channel whose transfer completes in this mode becomes lowest ranked, and the channel after it becomes highest. After reset, channel 0 is highest.
- R8: `gnt` is one-hot or zero and names a channel that requested it. `gnt` appears one cycle after the request is sampled with no grant active. It then holds, whatever the requests do, until `done` is sampled. After `done`, `gnt` stays 0 for at least one cycle.
- R9: An `addr_err` pulse forces `gnt` to 0 in that same cycle and sets bit 2 of the control word from the next cycle. While bit 2 is 1, `gnt` stays 0.
- R10: Writing 1 to bit 2 never sets it.
- R11: A write with bit 2 equal to 0 clears bit 2 only when the last register access before it was a read that returned bit 2 as 1. Otherwise bit 2 stays set.
- R12: Only address `CTRL_ADDR` (default 0) holds the word. At other addresses, writes change nothing and reads return 0. Read data is valid in the same cycle as `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Per-channel transfer requests |
| done | input | 1 | Transfer-complete strobe for the granted channel |
| addr_err | input | 1 | Address fault pulse from the transfer engine |
| gnt | output | 4 | One-hot grant |
| reg_addr | input | 4 | Register port address |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |

## Verification
The results fall due at different times:
- A grant is due on the cycle after the clock edge that samples a request in `ST_IDLE`.
- A dropped grant on a fault is due in the same cycle as `addr_err`.
- The fault bit becomes visible in read data one edge after the pulse.
- A grant returns two edges after the clearing write: one edge to reach `ST_IDLE` and one to grant.

The bench drives inputs on falling edges and samples on the following falling edge, so each check lands exactly one register stage later. Combinational results (read data and the fault-gated grant) are sampled 1 ns after the falling edge that applied the stimulus.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    localparam int NCH     = 4;
    localparam int CW      = $clog2(NCH);
    localparam int RW      = 16;
    localparam int MODE_LO = 8;
    localparam int ERR_BIT = 2;

    typedef enum logic [1:0] {
        MODE_ASC    = 2'b00,
        MODE_SKIP1  = 2'b01,
        MODE_CH2TOP = 2'b10,
        MODE_ROTATE = 2'b11
    } arb_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_GRANT = 2'b01,
        ST_HALT  = 2'b10
    } arb_state_e;

    // Channel that sits at position r (0 = highest) of the given ordering.
    function automatic logic [CW-1:0] rank_to_ch(input logic [1:0] m,
                                                 input logic [CW-1:0] base,
                                                 input logic [CW-1:0] r);
        logic [CW-1:0] c;
        unique case (m)
            MODE_ASC:   c = r;
            MODE_SKIP1: begin
                unique case (r)
                    2'd0:    c = 2'd0;
                    2'd1:    c = 2'd2;
                    2'd2:    c = 2'd3;
                    default: c = 2'd1;
                endcase
            end
            MODE_CH2TOP: begin
                unique case (r)
                    2'd0:    c = 2'd2;
                    2'd1:    c = 2'd0;
                    2'd2:    c = 2'd1;
                    default: c = 2'd3;
                endcase
            end
            default:    c = base + r;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/dpa_ctrl_reg.sv
module dpa_ctrl_reg
    import dpa_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [RW-1:0]     reg_wdata,
    input  logic              err_in,
    output logic [RW-1:0]     reg_rdata,
    output logic [1:0]        mode,
    output logic              err_flag
);
    logic hit;
    logic armed_q;

    assign hit = (reg_addr == ADDR_W'(CTRL_ADDR));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_ASC;
            err_flag <= 1'b0;
            armed_q  <= 1'b0;
        end else begin
            if (hit && reg_we)
                mode <= reg_wdata[MODE_LO+1:MODE_LO];
            // Fault report wins over a simultaneous clearing write.
            if (err_in)
                err_flag <= 1'b1;
            else if (hit && reg_we && armed_q && !reg_wdata[ERR_BIT])
                err_flag <= 1'b0;
            // The clear is armed by a read that saw the flag; any write disarms it.
            if (hit && reg_we)
                armed_q <= 1'b0;
            else if (hit && reg_re && err_flag)
                armed_q <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit && reg_re) begin
            reg_rdata[MODE_LO+1:MODE_LO] = mode;
            reg_rdata[ERR_BIT]           = err_flag;
        end
    end

    assert_flag_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(err_in));
    assert_clear_seq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> ($past(hit && reg_we && !reg_wdata[ERR_BIT]) && $past(armed_q)));
    assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~(RW'(3) << MODE_LO) & ~(RW'(1) << ERR_BIT)) == '0);
    assert_miss_reads0_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> reg_rdata == '0);
endmodule

// File: rtl/dpa_pick.sv
module dpa_pick
    import dpa_pkg::*;
(
    input  logic [NCH-1:0] req,
    input  logic [1:0]     mode,
    input  logic [CW-1:0]  base,
    output logic           any,
    output logic [CW-1:0]  sel
);
    logic [CW-1:0] rank_ch [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_rank
        assign rank_ch[g] = rank_to_ch(mode, base, CW'(g));
    end

    // Walk from lowest rank to highest so the highest requester wins.
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            if (req[rank_ch[k]]) begin
                any = 1'b1;
                sel = rank_ch[k];
            end
        end
    end
endmodule

// File: rtl/dpa_grant_fsm.sv
module dpa_grant_fsm
    import dpa_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           any,
    input  logic [CW-1:0]  sel,
    input  logic [1:0]     mode,
    input  logic           done,
    input  logic           err_in,
    input  logic           err_flag,
    output logic [NCH-1:0] gnt,
    output logic [CW-1:0]  base
);
    arb_state_e    state_q, state_d;
    logic [CW-1:0] sel_q;
    logic          stop;

    assign stop = err_in || err_flag;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (stop) state_d = ST_HALT;
                      else if (any) state_d = ST_GRANT;
            ST_GRANT: if (stop) state_d = ST_HALT;
                      else if (done) state_d = ST_IDLE;
            ST_HALT:  if (!stop) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            base    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_GRANT)
                sel_q <= sel;
            if (state_q == ST_GRANT && state_d == ST_IDLE && mode == MODE_ROTATE)
                base <= sel_q + CW'(1);
        end
    end

    always_comb begin
        gnt = '0;
        if (state_q == ST_GRANT && !err_in)
            gnt = NCH'(1) << sel_q;
    end

    assert_gnt_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_gnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && !done) |=> (err_in || gnt == $past(gnt)));
    assert_gap_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && done) |=> gnt == '0);
    assert_halt_nognt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag || err_in) |-> gnt == '0);
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dpa_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        req,
    input  logic              done,
    input  logic              addr_err,
    output logic [3:0]        gnt,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata
);
    logic [1:0]    mode;
    logic          err_flag;
    logic          any;
    logic [CW-1:0] sel;
    logic [CW-1:0] base;

    dpa_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_re(reg_re), .reg_wdata(reg_wdata), .err_in(addr_err),
        .reg_rdata(reg_rdata), .mode(mode), .err_flag(err_flag)
    );

    dpa_pick u_pick (
        .req(req), .mode(mode), .base(base), .any(any), .sel(sel)
    );

    dpa_grant_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .any(any), .sel(sel), .mode(mode),
        .done(done), .err_in(addr_err), .err_flag(err_flag),
        .gnt(gnt), .base(base)
    );

    assert_gnt_from_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|gnt) |-> (gnt & $past(req)) != '0);
endmodule

// File: tb/sim_dma_prio_arb.sv
module sim_dma_prio_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req = '0;
    logic        done = 1'b0;
    logic        addr_err = 1'b0;
    logic [3:0]  gnt;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    dma_prio_arb u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .done(done), .addr_err(addr_err),
        .gnt(gnt), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // {mode[1:0], req[3:0], expected gnt[3:0]}
    localparam logic [9:0] VEC [12] = '{
        {2'b00, 4'b1111, 4'b0001}, {2'b00, 4'b1110, 4'b0010},
        {2'b00, 4'b1100, 4'b0100}, {2'b00, 4'b1010, 4'b0010},
        {2'b01, 4'b1111, 4'b0001}, {2'b01, 4'b1010, 4'b1000},
        {2'b01, 4'b0110, 4'b0100}, {2'b01, 4'b0010, 4'b0010},
        {2'b10, 4'b1111, 4'b0100}, {2'b10, 4'b1011, 4'b0001},
        {2'b10, 4'b1010, 4'b0010}, {2'b10, 4'b1000, 4'b1000}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic finish_xfer();
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 gnt", {12'd0, gnt}, 16'h0);
        rd(4'd0, v); chk("R1 reg", v, 16'h0000);

        // Fixed-order table walk (R4, R5, R6)
        for (int i = 0; i < 12; i++) begin
            wr(4'd0, {6'd0, VEC[i][9:8], 8'd0});
            @(negedge clk);
            req = VEC[i][7:4];
            @(negedge clk);
            chk(VEC[i][9:8] == 2'b00 ? "R4 order" :
                VEC[i][9:8] == 2'b01 ? "R5 order" : "R6 order",
                {12'd0, gnt}, {12'd0, VEC[i][3:0]});
            finish_xfer();
            req = '0;
            chk("R8 gap", {12'd0, gnt}, 16'h0);
        end

        // Register field behaviour
        wr(4'd0, 16'hFFFF);
        rd(4'd0, v); chk("R3 R2 R10 readback", v, 16'h0300);
        wr(4'd5, 16'h0100);
        rd(4'd0, v); chk("R12 miss write", v, 16'h0300);
        rd(4'd5, v); chk("R12 miss read", v, 16'h0000);
        wr(4'd0, 16'h0004);
        rd(4'd0, v); chk("R10 write one", v, 16'h0000);

        // Round robin (R7)
        wr(4'd0, 16'h0300);
        @(negedge clk);
        req = 4'b1111;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R7 rotate", {12'd0, gnt}, 16'(4'b0001 << (k % 4)));
            finish_xfer();
        end
        req = 4'b1001;
        @(negedge clk); chk("R7 after ch0", {12'd0, gnt}, 16'h0008);
        finish_xfer();
        @(negedge clk); chk("R7 wrap", {12'd0, gnt}, 16'h0001);
        finish_xfer();
        req = '0;

        // Hold until done (R8)
        wr(4'd0, 16'h0200);
        @(negedge clk); req = 4'b0001;
        @(negedge clk); chk("R8 first", {12'd0, gnt}, 16'h0001);
        req = 4'b1111;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); chk("R8 hold", {12'd0, gnt}, 16'h0001);
        end
        finish_xfer();
        chk("R8 idle cycle", {12'd0, gnt}, 16'h0);
        @(negedge clk); chk("R8 regrant", {12'd0, gnt}, 16'h0004);
        finish_xfer();
        req = '0;

        // Fault during grant (R9, R11)
        wr(4'd0, 16'h0000);
        @(negedge clk); req = 4'b0010;
        @(negedge clk); chk("R9 pre", {12'd0, gnt}, 16'h0002);
        @(negedge clk); addr_err = 1'b1;
        #1 chk("R9 same cycle drop", {12'd0, gnt}, 16'h0);
        @(negedge clk); addr_err = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); chk("R9 blocked", {12'd0, gnt}, 16'h0);
        end
        wr(4'd0, 16'h0000);
        rd(4'd0, v); chk("R11 blind clear", v, 16'h0004);
        wr(4'd0, 16'h0004);
        wr(4'd0, 16'h0000);
        rd(4'd0, v); chk("R11 disarmed", v, 16'h0004);
        chk("R9 still blocked", {12'd0, gnt}, 16'h0);
        wr(4'd0, 16'h0000);
        rd(4'd0, v); chk("R11 cleared", v, 16'h0000);
        @(negedge clk); chk("R9 resume", {12'd0, gnt}, 16'h0002);
        finish_xfer();
        req = '0;

        // Fault with no grant active (R9)
        @(negedge clk); addr_err = 1'b1;
        @(negedge clk); addr_err = 1'b0; req = 4'b0001;
        rd(4'd0, v); chk("R9 idle fault", v, 16'h0004);
        chk("R9 idle blocked", {12'd0, gnt}, 16'h0);
        wr(4'd0, 16'h0000);
        @(negedge clk);
        @(negedge clk); chk("R11 resume", {12'd0, gnt}, 16'h0001);
        finish_xfer();
        req = '0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule